// File: doc/BRIEF.md
# Converter Overcurrent and Short-Circuit Detector

This block supervises one switching converter through two digital comparator outputs: a current-limit comparator and an output-undervoltage comparator that reports the output sitting below the short-circuit threshold. It turns these raw levels into debounced fault indications. A current limit that persists for the qualification time raises an event and a live status level, but leaves the converter running.

Short circuits are caught in two distinct ways. At start-up, the undervoltage comparator is sampled exactly once, a fixed time after the converter is enabled. A high sample means the output never came up. During steady operation, a separate overload watch requires the undervoltage comparator to stay high for the same length of time before it acts. Either fault raises its own one-cycle event and a disable request that keeps the converter off until enable is dropped and raised again.

All timing comes from a clock-frequency parameter and two durations in nanoseconds. The block converts these into cycle counts at elaboration time.

Top module: `conv_fault_detector`

## Requirements
- R1: During and right after synchronous reset, every output (`ilim_active_o`, `ilim_evt_o`, `sc_evt_o`, `ovl_evt_o`, `conv_off_req_o`) is low and the detector is idle.
- R2: While the converter is enabled and not tripped, `ilim_active_o` rises right after the ILIM-th consecutive rising edge that samples `ilim_cmp_i` high. ILIM is the number of cycles in `ILIM_NS` at `CLK_KHZ`, rounded down and at least 1. `ilim_evt_o` is high for exactly that first cycle of the level. The level falls one edge after the comparator is sampled low.
- R3: Any edge that samples a comparator low while its watch is counting restarts that count from zero. This applies to current limit and to overload.
- R4: A qualified current limit never raises `conv_off_req_o`.
- R5: Enable is registered at edge E0. `uv_cmp_i` is sampled at edge E_SC, the SC-th edge after E0, where SC is the number of cycles in `SC_NS`. A high sample pulses `sc_evt_o` for one cycle and raises `conv_off_req_o` in that same cycle.
- R6: Before and after the edge E_SC, a single-cycle high on `uv_cmp_i` does not cause a trip.
- R7: After a clean start-up, `uv_cmp_i` sampled high on SC consecutive edges raises `ovl_evt_o` for one cycle, together with `conv_off_req_o`, one edge after the SC-th sample. Fewer consecutive samples do not cause a trip.
- R8: `conv_off_req_o` stays high while `conv_en_i` stays high. It falls one edge after `conv_en_i` is sampled low, and a new enable starts a fresh start-up check.
- R9: Sampling `conv_en_i` low clears every timer. After re-enable, the start-up window and the current-limit count begin again from zero.
- R10: The cycle counts are derived from `CLK_KHZ`, `ILIM_NS` and `SC_NS` as floor(CLK_KHZ·ns/10^6), with a minimum of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_en_i | input | 1 | Converter enable request |
| ilim_cmp_i | input | 1 | Current-limit comparator, high when limiting |
| uv_cmp_i | input | 1 | Output-below-short-circuit-threshold comparator |
| ilim_active_o | output | 1 | Debounced current-limit level |
| ilim_evt_o | output | 1 | One-cycle pulse when a current limit qualifies |
| sc_evt_o | output | 1 | One-cycle pulse for a start-up short circuit |
| ovl_evt_o | output | 1 | One-cycle pulse for a run-time overload |
| conv_off_req_o | output | 1 | Request to hold the converter disabled |

## Verification
The start-up check is swept with a single-cycle undervoltage pulse at every edge from E0 to one past the window. This separates the one-sample rule from a level-sensitive check and also exposes an off-by-one window. Current-limit and overload pulses are swept over lengths 1 to N+1, which fixes the exact qualification edge and shows that pulses one cycle short do nothing. Interrupted pulses show that a count restarts rather than accumulates. Enable is also dropped in the middle of the start-up window and in the middle of a current-limit count, to confirm that all timing restarts.

// File: rtl/conv_fault_pkg.sv
package conv_fault_pkg;

    typedef enum logic [1:0] {
        CF_IDLE  = 2'd0,
        CF_START = 2'd1,
        CF_RUN   = 2'd2,
        CF_TRIP  = 2'd3
    } cf_state_e;

    typedef struct packed {
        logic sc;
        logic ovl;
    } cf_evt_t;

    // Cycles spanned by a duration in ns at a clock given in kHz (R10).
    function automatic int unsigned ns_to_cycles(int unsigned khz, int unsigned ns);
        longint unsigned prod;
        longint unsigned cyc;
        prod = 64'(khz) * 64'(ns);
        cyc  = prod / 64'd1000000;
        if (cyc == 64'd0) cyc = 64'd1;
        return 32'(cyc);
    endfunction

endpackage

// File: rtl/cf_debounce.sv
module cf_debounce #(
    parameter int unsigned LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic raw,
    output logic q,
    output logic rise
);
    localparam int unsigned W = $clog2(LEN + 1);

    logic [W-1:0] cnt;
    logic         q_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!(arm && raw)) begin
            cnt <= '0;
        end else if (cnt != W'(LEN)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign q = (cnt == W'(LEN));

    always_ff @(posedge clk) begin
        if (rst) q_prev <= 1'b0;
        else     q_prev <= q;
    end

    assign rise = q && !q_prev;

    // R2: a qualified level only appears after a sampled, armed comparator
    a_r2_rise_needs_input: assert property (@(posedge clk) disable iff (rst)
        $rose(q) |-> $past(arm && raw));

    // R3: a low or disarmed sample drops the level at the next edge
    a_r3_restart: assert property (@(posedge clk) disable iff (rst)
        !(arm && raw) |=> !q);

endmodule

// File: rtl/cf_start_window.sv
module cf_start_window #(
    parameter int unsigned LEN = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int unsigned W = $clog2(LEN + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != W'(LEN - 1)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == W'(LEN - 1));

endmodule

// File: rtl/conv_fault_detector.sv
module conv_fault_detector
    import conv_fault_pkg::*;
#(
    parameter int unsigned CLK_KHZ = 100000,
    parameter int unsigned ILIM_NS = 20000,
    parameter int unsigned SC_NS   = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic conv_en_i,
    input  logic ilim_cmp_i,
    input  logic uv_cmp_i,
    output logic ilim_active_o,
    output logic ilim_evt_o,
    output logic sc_evt_o,
    output logic ovl_evt_o,
    output logic conv_off_req_o
);
    localparam int unsigned ILIM_CYC = ns_to_cycles(CLK_KHZ, ILIM_NS);
    localparam int unsigned SC_CYC   = ns_to_cycles(CLK_KHZ, SC_NS);

    cf_state_e state;
    cf_evt_t   evt_q;
    logic      win_done;
    logic      ilim_q;
    logic      ilim_rise;
    logic      ovl_q;
    logic      ovl_rise;

    wire win_run  = conv_en_i && (state == CF_START);
    wire ilim_arm = conv_en_i && ((state == CF_START) || (state == CF_RUN));
    wire ovl_arm  = conv_en_i && (state == CF_RUN);

    cf_start_window #(.LEN(SC_CYC)) u_window (
        .clk  (clk),
        .rst  (rst),
        .run  (win_run),
        .done (win_done)
    );

    cf_debounce #(.LEN(ILIM_CYC)) u_ilim (
        .clk  (clk),
        .rst  (rst),
        .arm  (ilim_arm),
        .raw  (ilim_cmp_i),
        .q    (ilim_q),
        .rise (ilim_rise)
    );

    cf_debounce #(.LEN(SC_CYC)) u_ovl (
        .clk  (clk),
        .rst  (rst),
        .arm  (ovl_arm),
        .raw  (uv_cmp_i),
        .q    (ovl_q),
        .rise (ovl_rise)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CF_IDLE;
            evt_q <= '0;
        end else begin
            evt_q <= '0;
            if (!conv_en_i) begin
                state <= CF_IDLE;
            end else begin
                case (state)
                    CF_IDLE:  state <= CF_START;
                    CF_START: begin
                        if (win_done) begin
                            if (uv_cmp_i) begin
                                state    <= CF_TRIP;
                                evt_q.sc <= 1'b1;
                            end else begin
                                state <= CF_RUN;
                            end
                        end
                    end
                    CF_RUN: begin
                        if (ovl_q) begin
                            state     <= CF_TRIP;
                            evt_q.ovl <= 1'b1;
                        end
                    end
                    default: state <= CF_TRIP;
                endcase
            end
        end
    end

    assign ilim_active_o  = ilim_q;
    assign ilim_evt_o     = ilim_rise;
    assign sc_evt_o       = evt_q.sc;
    assign ovl_evt_o      = evt_q.ovl;
    assign conv_off_req_o = (state == CF_TRIP);

    // R2: the event pulse only accompanies an active level
    a_r2_evt_with_level: assert property (@(posedge clk) disable iff (rst)
        ilim_evt_o |-> ilim_active_o);

    // R4: the disable request only starts with a short-circuit or overload event
    a_r4_off_has_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_off_req_o) |-> (sc_evt_o || ovl_evt_o));

    // R5: a start-up trip reflects a high undervoltage sample
    a_r5_sc_sampled: assert property (@(posedge clk) disable iff (rst)
        sc_evt_o |-> $past(uv_cmp_i));

    // R7: an overload trip follows a qualified overload level
    a_r7_ovl_qualified: assert property (@(posedge clk) disable iff (rst)
        ovl_evt_o |-> $past(ovl_q));

    // R8: a tripped converter stays off while enable is held
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        conv_off_req_o && conv_en_i |=> conv_off_req_o);

    // R9: dropping enable clears the request and the current-limit level
    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        !conv_en_i |=> (!conv_off_req_o && !ilim_active_o));

    // R10: derived counts are usable
    initial begin
        a_r10_counts: assert (ILIM_CYC >= 1 && SC_CYC >= 1);
    end

endmodule

// File: tb/conv_fault_detector_tb.sv
module conv_fault_detector_tb;

    localparam int unsigned CLK_KHZ = 100000;
    localparam int unsigned ILIM_NS = 40;
    localparam int unsigned SC_NS   = 60;
    // R10: expected cycle counts computed in the bench
    localparam int N  = (CLK_KHZ * ILIM_NS) / 1000000;
    localparam int SC = (CLK_KHZ * SC_NS) / 1000000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic conv_en = 1'b0;
    logic ilim = 1'b0;
    logic uv = 1'b0;
    logic ilim_active, ilim_evt, sc_evt, ovl_evt, off_req;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    conv_fault_detector #(
        .CLK_KHZ(CLK_KHZ), .ILIM_NS(ILIM_NS), .SC_NS(SC_NS)
    ) u_dut (
        .clk(clk), .rst(rst), .conv_en_i(conv_en), .ilim_cmp_i(ilim),
        .uv_cmp_i(uv), .ilim_active_o(ilim_active), .ilim_evt_o(ilim_evt),
        .sc_evt_o(sc_evt), .ovl_evt_o(ovl_evt), .conv_off_req_o(off_req)
    );

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic go_idle();
        conv_en = 1'b0; uv = 1'b0; ilim = 1'b0;
        step(); step();
    endtask

    task automatic go_run();
        conv_en = 1'b1; uv = 1'b0; ilim = 1'b0;
        repeat (SC + 1) step();
        chk("R5 clean start no trip", off_req, 1'b0);
    endtask

    initial begin
        repeat (3) step();
        chk("R1 reset off_req", off_req, 1'b0);
        chk("R1 reset ilim_active", ilim_active, 1'b0);
        chk("R1 reset sc_evt", sc_evt, 1'b0);
        rst = 1'b0;
        step();
        chk("R1 idle off_req", off_req, 1'b0);
        chk("R1 idle ovl_evt", ovl_evt, 1'b0);
        chk("R1 idle ilim_evt", ilim_evt, 1'b0);

        // R5 / R6: one-cycle undervoltage pulse at each start-up edge
        for (int k = 0; k <= SC + 1; k++) begin
            conv_en = 1'b1;
            for (int e = 0; e <= SC + 1; e++) begin
                uv = (e == k);
                step();
                if (e == SC) begin
                    chk("R5 off_req at sample edge", off_req, (k == SC));
                    chk("R6 sc_evt only at sample edge", sc_evt, (k == SC));
                end
            end
            uv = 1'b0;
            step();
            chk("R6 off_req after window", off_req, (k == SC));
            chk("R5 sc_evt single cycle", sc_evt, 1'b0);
            go_idle();
        end

        // R2 / R4: current-limit pulse lengths 1..N+1
        for (int len = 1; len <= N + 1; len++) begin
            go_run();
            ilim = 1'b1;
            for (int i = 1; i <= len; i++) begin
                step();
                chk("R2 ilim_active", ilim_active, (i >= N));
                chk("R2 ilim_evt", ilim_evt, (i == N));
                chk("R4 no off_req on ilim", off_req, 1'b0);
            end
            ilim = 1'b0;
            step();
            chk("R2 ilim_active falls", ilim_active, 1'b0);
            chk("R2 ilim_evt after release", ilim_evt, 1'b0);
            go_idle();
        end

        // R3: interrupted current limit restarts
        go_run();
        ilim = 1'b1;
        repeat (N - 1) step();
        ilim = 1'b0;
        step();
        ilim = 1'b1;
        repeat (N - 1) step();
        chk("R3 ilim restart no qualify", ilim_active, 1'b0);
        step();
        chk("R3 ilim qualifies after N", ilim_active, 1'b1);
        go_idle();

        // R7: overload pulse lengths 1..SC+1
        for (int len = 1; len <= SC + 1; len++) begin
            go_run();
            uv = 1'b1;
            for (int i = 1; i <= len; i++) begin
                step();
                chk("R7 off_req during overload", off_req, (i >= SC + 1));
                chk("R7 ovl_evt timing", ovl_evt, (i == SC + 1));
            end
            uv = 1'b0;
            step();
            chk("R7 off_req after overload", off_req, (len >= SC));
            chk("R7 ovl_evt on release edge", ovl_evt, (len == SC));
            go_idle();
        end

        // R3: interrupted overload restarts
        go_run();
        uv = 1'b1;
        repeat (SC - 1) step();
        uv = 1'b0;
        step();
        uv = 1'b1;
        repeat (SC - 1) step();
        step();
        chk("R3 ovl restart no trip", off_req, 1'b0);
        step();
        chk("R3 ovl trips after full run", off_req, 1'b1);
        go_idle();

        // R8: tripped converter held off, release, fresh start-up
        conv_en = 1'b1; uv = 1'b1;
        repeat (SC + 1) step();
        chk("R8 tripped", off_req, 1'b1);
        uv = 1'b0;
        repeat (10) step();
        chk("R8 held while enabled", off_req, 1'b1);
        conv_en = 1'b0;
        step();
        chk("R8 released on enable low", off_req, 1'b0);
        go_run();
        chk("R8 re-enable runs", off_req, 1'b0);
        go_idle();

        // R9: enable dropped mid-window restarts start-up window
        conv_en = 1'b1; uv = 1'b1;
        repeat (3) step();
        conv_en = 1'b0;
        step();
        conv_en = 1'b1;
        for (int e = 0; e <= SC; e++) begin
            step();
            chk("R9 window restarted", off_req, (e == SC));
        end
        go_idle();

        // R9: enable dropped mid-count clears current-limit count
        go_run();
        ilim = 1'b1;
        repeat (N - 1) step();
        conv_en = 1'b0;
        step();
        chk("R9 ilim cleared", ilim_active, 1'b0);
        conv_en = 1'b1;
        step();
        repeat (N - 1) step();
        chk("R9 ilim count restarted", ilim_active, 1'b0);
        step();
        chk("R9 ilim qualifies after restart", ilim_active, 1'b1);
        go_idle();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule